// File: doc/BRIEF.md
# Single and Double Tap Detector

The block watches acceleration magnitude samples on up to three axes. A new set of samples arrives on each sample strobe. It turns threshold crossings into tap events. A tap is a short excursion above a programmable threshold on any enabled axis. The excursion must return below the threshold within a programmable number of samples. The first tap raises a one-clock single-tap pulse. A second tap that follows at the right distance raises a one-clock double-tap pulse instead.

Double-tap timing uses two back-to-back intervals, both counted in sample strobes. A latency interval starts right after the first tap. A window interval follows it, and the second tap must fit inside the window. A suppress bit in the axis control word sets how taps inside latency are treated. With suppress clear, they are ignored. With suppress set, a tap completing inside latency abandons the double-tap attempt.

The sequencer has three states:
- IDLE waits for a first tap.
- LATENCY counts latency strobes.
- WINDOW counts window strobes and waits for the second tap.

Its transitions are:
- IDLE to LATENCY on a first tap.
- LATENCY to WINDOW when latency is used up.
- LATENCY to IDLE on a suppressed cancel.
- WINDOW to IDLE on a double tap or on window expiry.
- Any state to IDLE when double tap is disabled.

Each axis has its own tap qualifier with three states:
- LOW: the sample is at or below the threshold.
- HIGH: the excursion is being timed against the duration.
- HOLD: the excursion ran too long and is discarded.

Top module: `tap_detector`

## Requirements
- R1: A sample is above threshold only when it is strictly greater than `thresh`. A sample equal to `thresh` never starts a tap.
- R2: A tap completes on the first below-threshold strobe after 1 to `dur_cnt` consecutive above-threshold strobes. A first tap completing in IDLE with `single_en`=1 gives `single_tap`=1 for the one clock after that strobe.
- R3: An excursion of more than `dur_cnt` above-threshold strobes is discarded and gives no pulse. No new tap starts on that axis until it drops below threshold. With `dur_cnt`=0 no tap is ever recognised.
- R4: Bits 2:0 of `tap_ctrl` enable the axes. Bit 0 is Z, which is sample bits [7:0]. Bit 1 is Y, which is [15:8]. Bit 2 is X, which is [23:16]. A disabled axis never contributes a tap.
- R5: A first tap with `double_en`=1 and non-zero `lat_cnt` and `win_cnt` is followed by `lat_cnt` latency strobes. With `tap_ctrl[3]`=0, a tap inside latency gives no pulse and does not end the sequence.
- R6: The `win_cnt` strobes after latency form the window. A tap that both starts and completes in the window gives `double_tap`=1 for one clock after its completing strobe, gives no single pulse, and returns to IDLE. A tap completing on the last window strobe still counts.
- R7: With `tap_ctrl[3]`=1, a tap completing inside latency cancels the sequence to IDLE. No double tap is then reported, and the next tap is a new first tap.
- R8: When the window ends without a second tap, the sequencer returns to IDLE. A tap completing after that is a first tap.
- R9: With `double_en`=0, or with `lat_cnt`=0 or `win_cnt`=0, no double-tap pulse is produced and every tap is a first tap.
- R10: Both pulses are low after reset, last one clock, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe; one sample set per high cycle |
| smp_val | input | 24 | Axis magnitudes: Z [7:0], Y [15:8], X [23:16] |
| tap_ctrl | input | 4 | Axis enables [2:0] (Z at bit 0), suppress at bit 3 |
| thresh | input | 8 | Tap threshold |
| dur_cnt | input | 8 | Longest tap in strobes |
| lat_cnt | input | 8 | Latency length in strobes |
| win_cnt | input | 8 | Window length in strobes |
| single_en | input | 1 | Enable single-tap pulses |
| double_en | input | 1 | Enable double-tap sequencing |
| single_tap | output | 1 | One-clock single-tap pulse |
| double_tap | output | 1 | One-clock double-tap pulse |

## Verification
The hardest case to reach from the ports is a tap whose edges straddle a sequencer boundary. One such tap rises on the last window strobe and falls after expiry. Another starts inside latency and ends inside the window. The stimulus reaches these by counting strobes exactly from the completing strobe of the first tap. Quiet runs are sized so that the second tap rises and falls on chosen window positions. The same sequences are then repeated with random amplitudes, random axes and random gaps between strobes.

// File: rtl/tapdet_pkg.sv
package tapdet_pkg;
    typedef enum logic [1:0] {
        Q_LOW  = 2'd0,
        Q_HIGH = 2'd1,
        Q_HOLD = 2'd2
    } qual_state_t;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_LATENCY = 2'd1,
        S_WINDOW  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/tapdet_qual.sv
module tapdet_qual
    import tapdet_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          en,
    input  logic          above,
    input  logic [CW-1:0] dur,
    output logic          rise,
    output logic          done
);
    localparam logic [CW-1:0] ONE = CW'(1);

    qual_state_t   st;
    logic [CW-1:0] cnt;

    always_comb begin
        rise = en && stb && (st == Q_LOW) && above;
        done = en && stb && (st == Q_HIGH) && !above;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st  <= Q_LOW;
            cnt <= '0;
        end else if (stb) begin
            unique case (st)
                Q_LOW: begin
                    if (above) begin
                        if (dur == '0) begin
                            st <= Q_HOLD;
                        end else begin
                            st  <= Q_HIGH;
                            cnt <= ONE;
                        end
                    end
                end
                Q_HIGH: begin
                    if (!above) begin
                        st <= Q_LOW;
                    end else if (cnt == dur) begin
                        st <= Q_HOLD;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                Q_HOLD: begin
                    if (!above) st <= Q_LOW;
                end
                default: st <= Q_LOW;
            endcase
        end
    end

    // R4: a disabled axis never reports an edge or a tap
    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!rise && !done));

    // R3: a discarded excursion cannot start a new tap until it drops
    p_hold_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == Q_HOLD && stb && en && above) |=> (st == Q_HOLD && !done));
endmodule

// File: rtl/tapdet_seq.sv
module tapdet_seq
    import tapdet_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          tap_rise,
    input  logic          tap_done,
    input  logic          suppress,
    input  logic [CW-1:0] lat,
    input  logic [CW-1:0] win,
    input  logic          single_en,
    input  logic          double_en,
    output logic          single_tap,
    output logic          double_tap
);
    localparam logic [CW-1:0] ONE = CW'(1);

    seq_state_t    st;
    logic [CW-1:0] cnt;
    logic          armed;
    logic [CW-1:0] cnt_nx;

    assign cnt_nx = cnt + ONE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            cnt   <= '0;
            armed <= 1'b0;
        end else if (!double_en) begin
            st    <= S_IDLE;
            armed <= 1'b0;
        end else if (stb) begin
            unique case (st)
                S_IDLE: begin
                    if (tap_done && lat != '0 && win != '0) begin
                        st  <= S_LATENCY;
                        cnt <= '0;
                    end
                end
                S_LATENCY: begin
                    if (tap_done && suppress) begin
                        st <= S_IDLE;
                    end else if (cnt_nx == lat) begin
                        st    <= S_WINDOW;
                        cnt   <= '0;
                        armed <= 1'b0;
                    end else begin
                        cnt <= cnt_nx;
                    end
                end
                S_WINDOW: begin
                    if (tap_rise) armed <= 1'b1;
                    if ((tap_done && armed) || cnt_nx == win) begin
                        st <= S_IDLE;
                    end else begin
                        cnt <= cnt_nx;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_tap <= 1'b0;
            double_tap <= 1'b0;
        end else begin
            single_tap <= tap_done && (st == S_IDLE) && single_en;
            double_tap <= tap_done && (st == S_WINDOW) && armed && double_en;
        end
    end

    // R10: pulses are exclusive and last one clock
    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(single_tap && double_tap));
    p_single_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        single_tap |=> !single_tap);
    p_double_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        double_tap |=> !double_tap);
    // R2: a single pulse follows a completed tap with single taps enabled
    p_single_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        single_tap |-> $past(tap_done && single_en));
    // R9: no double pulse unless double taps were enabled
    p_double_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        double_tap |-> $past(tap_done && double_en && stb));
    // R7: a suppressed tap in latency ends the sequence
    p_suppress_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LATENCY && tap_done && suppress && double_en) |=> (st == S_IDLE));
endmodule

// File: rtl/tap_detector.sv
module tap_detector
    import tapdet_pkg::*;
#(
    parameter int NAX = 3,
    parameter int W   = 8,
    parameter int CW  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic [NAX*W-1:0] smp_val,
    input  logic [NAX:0]     tap_ctrl,
    input  logic [W-1:0]     thresh,
    input  logic [CW-1:0]    dur_cnt,
    input  logic [CW-1:0]    lat_cnt,
    input  logic [CW-1:0]    win_cnt,
    input  logic             single_en,
    input  logic             double_en,
    output logic             single_tap,
    output logic             double_tap
);
    localparam int SUPP_BIT = NAX;

    logic [NAX-1:0] ax_rise;
    logic [NAX-1:0] ax_done;

    for (genvar i = 0; i < NAX; i++) begin : g_axis
        logic above;
        assign above = smp_val[i*W +: W] > thresh;

        tapdet_qual #(.CW(CW)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (smp_stb),
            .en    (tap_ctrl[i]),
            .above (above),
            .dur   (dur_cnt),
            .rise  (ax_rise[i]),
            .done  (ax_done[i])
        );
    end

    tapdet_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (smp_stb),
        .tap_rise   (|ax_rise),
        .tap_done   (|ax_done),
        .suppress   (tap_ctrl[SUPP_BIT]),
        .lat        (lat_cnt),
        .win        (win_cnt),
        .single_en  (single_en),
        .double_en  (double_en),
        .single_tap (single_tap),
        .double_tap (double_tap)
    );

    // R1: no pulse may appear without a sample strobe one clock earlier
    p_pulse_after_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (single_tap || double_tap) |-> $past(smp_stb));
endmodule

// File: tb/tap_detector_bench.sv
`timescale 1ns/1ps
module tap_detector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic [23:0] smp_val = '0;
    logic [3:0]  tap_ctrl = 4'b0111;
    logic [7:0]  thresh = 8'd100;
    logic [7:0]  dur_cnt = 8'd3;
    logic [7:0]  lat_cnt = 8'd4;
    logic [7:0]  win_cnt = 8'd6;
    logic        single_en = 1'b1;
    logic        double_en = 1'b1;
    logic        single_tap, double_tap;

    int errs = 0, checks = 0, s_seen = 0, d_seen = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    tap_detector u_tap_detector (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_val(smp_val),
        .tap_ctrl(tap_ctrl), .thresh(thresh), .dur_cnt(dur_cnt),
        .lat_cnt(lat_cnt), .win_cnt(win_cnt), .single_en(single_en),
        .double_en(double_en), .single_tap(single_tap), .double_tap(double_tap)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    function automatic logic [7:0] hi_val();
        return thresh + 8'd1 + 8'($urandom % (255 - thresh));
    endfunction

    function automatic logic [7:0] lo_val();
        return 8'($urandom % (thresh + 1));
    endfunction

    // ax < 0 gives all axes below threshold
    function automatic logic [23:0] mkv(int ax);
        logic [23:0] v;
        for (int i = 0; i < 3; i++) v[i*8 +: 8] = (i == ax) ? hi_val() : lo_val();
        return v;
    endfunction

    task automatic observe();
        if (single_tap) s_seen++;
        if (double_tap) d_seen++;
        if (single_tap && double_tap) chk("R10 exclusive pulses", 1, 0);
    endtask

    task automatic strobe(logic [23:0] v);
        int gap;
        smp_val = v;
        smp_stb = 1'b1;
        @(negedge clk);
        observe();
        smp_stb = 1'b0;
        gap = $urandom % 3;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            observe();
        end
    endtask

    task automatic tap(int ax, int len);
        for (int k = 0; k < len; k++) strobe(mkv(ax));
        strobe(mkv(-1));
    endtask

    task automatic quiet(int n);
        for (int k = 0; k < n; k++) strobe(mkv(-1));
    endtask

    task automatic start();
        s_seen = 0;
        d_seen = 0;
    endtask

    task automatic expect_counts(string tag, int s, int d);
        chk({tag, " single"}, s_seen, s);
        chk({tag, " double"}, d_seen, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk("R10 reset single", int'(single_tap), 0);
        chk("R10 reset double", int'(double_tap), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: plain single tap
        start(); tap(0, 2); quiet(12); expect_counts("R2 single tap", 1, 0);
        // R1: equal to threshold is not above
        start();
        for (int k = 0; k < 2; k++) strobe({lo_val(), lo_val(), thresh});
        quiet(12); expect_counts("R1 equal threshold", 0, 0);
        // R3: too long discarded, then a tap of exactly dur_cnt counts
        start(); tap(1, 4); quiet(12); expect_counts("R3 too long", 0, 0);
        start(); tap(1, 3); quiet(12); expect_counts("R2 duration boundary", 1, 0);
        dur_cnt = 8'd0;
        start(); tap(2, 1); quiet(12); expect_counts("R3 zero duration", 0, 0);
        dur_cnt = 8'd3;
        // R4: Z (bit 0) disabled, X (bit 2) enabled
        tap_ctrl = 4'b0110;
        start(); tap(0, 1); quiet(12); expect_counts("R4 disabled Z", 0, 0);
        start(); tap(2, 1); quiet(12); expect_counts("R4 enabled X", 1, 0);
        tap_ctrl = 4'b0111;
        // R6: double tap
        start(); tap(0, 1); quiet(4); tap(1, 2); quiet(12);
        expect_counts("R6 double tap", 1, 1);
        // R6: completes on last window strobe
        start(); tap(0, 1); quiet(8); tap(0, 1); quiet(12);
        expect_counts("R6 last window strobe", 1, 1);
        // R8: rises on last window strobe, completes after expiry
        start(); tap(0, 1); quiet(9); tap(0, 1); quiet(12);
        expect_counts("R8 past window", 2, 0);
        // R8: full expiry then later tap
        start(); tap(2, 1); quiet(10); tap(2, 1); quiet(12);
        expect_counts("R8 expiry", 2, 0);
        // R5: tap in latency ignored with suppress clear
        start(); tap(0, 1); tap(1, 1); quiet(2); quiet(10);
        expect_counts("R5 latency ignored", 1, 0);
        start(); tap(0, 1); tap(1, 1); quiet(2); tap(2, 1); quiet(12);
        expect_counts("R5 latency then window", 1, 1);
        // R5: tap starting in latency and ending in window does not count
        start(); tap(0, 1); quiet(3); tap(1, 2); quiet(12);
        expect_counts("R5 straddling tap", 1, 0);
        // R7: suppress cancels
        tap_ctrl = 4'b1111;
        start(); tap(0, 1); tap(1, 1); quiet(2); tap(2, 1); quiet(12);
        expect_counts("R7 suppress cancel", 2, 0);
        start(); tap(0, 1); quiet(4); tap(1, 1); quiet(12);
        expect_counts("R7 suppress clean double", 1, 1);
        tap_ctrl = 4'b0111;
        // R9: double disabled, zero latency, zero window
        double_en = 1'b0;
        start(); tap(0, 1); quiet(4); tap(0, 1); quiet(12);
        expect_counts("R9 double disabled", 2, 0);
        double_en = 1'b1;
        lat_cnt = 8'd0;
        start(); tap(0, 1); quiet(4); tap(0, 1); quiet(12);
        expect_counts("R9 zero latency", 2, 0);
        lat_cnt = 8'd4;
        win_cnt = 8'd0;
        start(); tap(0, 1); quiet(4); tap(0, 1); quiet(12);
        expect_counts("R9 zero window", 2, 0);
        win_cnt = 8'd6;
        // R2: single pulses masked, double still reported
        single_en = 1'b0;
        start(); tap(1, 1); quiet(4); tap(1, 1); quiet(12);
        expect_counts("R2 single disabled", 0, 1);
        single_en = 1'b1;

        // R6 R2: random mix
        for (int it = 0; it < 30; it++) begin
            int l1, l2, a1, a2;
            l1 = 1 + $urandom % 3;
            l2 = 1 + $urandom % 3;
            a1 = $urandom % 3;
            a2 = $urandom % 3;
            start();
            if ($urandom % 2 == 0) begin
                tap(a1, l1); quiet(4); tap(a2, l2); quiet(12);
                expect_counts("R6 random double", 1, 1);
            end else begin
                tap(a1, l1); quiet(14);
                expect_counts("R2 random single", 1, 0);
            end
        end
        summary();
    end
endmodule